// File: doc/BRIEF.md
# Comparator Output Synchroniser with Change Flag

This block is the digital back end of a bank of analog comparators (two by default). Each channel receives one raw comparator result bit. The channel can force that bit to zero when it is disabled, and it can invert the result. The result is then captured into an output register. That register follows the result only while the first phase strobe of the four-phase system clock is high. While the device sleeps, the register follows the result on every cycle.

A register read by the CPU, qualified by the third phase strobe, copies the current output into a read-snapshot register. That snapshot is the value the CPU saw. A sticky change flag is raised whenever the live output differs from the snapshot. Software clears the flag with a write-zero. The PWM fault line is taken straight from the live output, so a register read or a flag clear can never remove a shutdown event.

One chosen channel has an extra option. Its copy for other peripherals can be re-registered on the falling edge of an external timer clock, detected in the system clock domain, instead of passing straight through.

Top module: `cmpout_sync_unit`

## Requirements
- R1: After reset, cmp_out, rd_data, chg_flag, shdn_out and per_out are all 0.
- R2: A channel whose cmp_en bit is 0 presents its cmp_inv bit as its output, whatever its raw bit is.
- R3: An enabled channel's output becomes cmp_raw XOR cmp_inv at the clock edge sampled with ph_q1 = 1. When ph_q1 = 0 and sleep_mode = 0, the output holds.
- R4: With sleep_mode = 1, the output follows the polarity-corrected result at every clock edge, whatever ph_q1 is.
- R5: rd_data takes the current cmp_out at an edge where reg_rd = 1 and ph_q3 = 1. reg_rd with ph_q3 = 0 leaves rd_data unchanged.
- R6: A channel's chg_flag bit becomes 1 at the edge after its cmp_out bit differs from its rd_data bit, and it stays 1 after the mismatch goes away.
- R7: A 1 on a flag_clr bit clears that flag at the next edge, unless a mismatch is present at that edge, in which case the flag stays set.
- R8: shdn_out always equals cmp_out and holds whenever cmp_out holds. Reads and flag clears have no effect on it.
- R9: For channel SYNC_CH (default 1), per_out takes the live output when sync_sel = 0. When sync_sel = 1, per_out updates only at the second clock edge after tmr_clk falls (two-register edge detect). Other channels always drive per_out from cmp_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_raw | input | N_CH | Raw comparator results |
| cmp_en | input | N_CH | Per-channel enable (0 forces a 0 into the inverter) |
| cmp_inv | input | N_CH | Per-channel polarity inversion |
| ph_q1 | input | 1 | First-phase strobe; output register follows while high |
| ph_q3 | input | 1 | Third-phase strobe; qualifies the read capture |
| sleep_mode | input | 1 | Sleep; keeps the output register following |
| reg_rd | input | 1 | Control register read strobe |
| flag_clr | input | N_CH | Write-zero clear of the change flags |
| tmr_clk | input | 1 | External timer clock for the sync option |
| sync_sel | input | 1 | 1 = resync channel SYNC_CH on timer falling edge |
| cmp_out | output | N_CH | Synchronised comparator outputs |
| per_out | output | N_CH | Outputs for other peripherals |
| rd_data | output | N_CH | Snapshot captured at the last read |
| chg_flag | output | N_CH | Sticky change interrupt flags |
| shdn_out | output | N_CH | PWM auto-shutdown fault lines |

## Verification
The vector table sweeps enable, inversion, raw and phase/sleep combinations. It separates the three sources of the output: a disabled channel yields the inversion bit, an enabled channel yields raw XOR inversion, and a vector without Q1 or sleep must show the previous value. The vectors with sleep set and Q1 clear tell the sleep path apart from the normal phase path.

Directed sequences then check that a read without Q3 captures nothing and that the flag survives the mismatch going away. They also check that a clear loses against a fresh mismatch, while the fault line stays on the live output through reads and clears. Finally, the timer option is run with the timer held high and then dropped, to show the two-edge latency and the bypass path.

// File: rtl/cmpout_pkg.sv
package cmpout_pkg;
   typedef enum logic {
      SYNC_BYPASS = 1'b0,
      SYNC_TIMER  = 1'b1
   } sync_mode_e;
endpackage

// File: rtl/cmpout_edge_det.sv
// Falling-edge detector for an external clock sampled in the system domain.
module cmpout_edge_det #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ext_in,
   output logic fall_pulse
);
   localparam int LAST = STAGES - 1;

   logic [LAST:0] shr;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("cmpout_edge_det needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shr <= '0;
      else        shr <= {shr[LAST-1:0], ext_in};
   end

   assign fall_pulse = shr[LAST] & ~shr[LAST-1];
endmodule

// File: rtl/cmpout_chan.sv
// One comparator channel: gate, polarity, phase register, read snapshot, flag.
module cmpout_chan (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   input  logic en,
   input  logic inv,
   input  logic follow,
   input  logic rd_cap,
   input  logic clr,
   output logic out_q,
   output logic snap_q,
   output logic flag_q
);
   logic gated;
   logic polar;

   assign gated = raw & en;
   assign polar = gated ^ inv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      out_q <= 1'b0;
      else if (follow) out_q <= polar;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      snap_q <= 1'b0;
      else if (rd_cap) snap_q <= out_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               flag_q <= 1'b0;
      else if (out_q != snap_q) flag_q <= 1'b1;
      else if (clr)             flag_q <= 1'b0;
   end
endmodule

// File: rtl/cmpout_sync_unit.sv
module cmpout_sync_unit
   import cmpout_pkg::*;
#(
   parameter int N_CH    = 2,
   parameter int SYNC_CH = 1,
   parameter int DET_STG = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_CH-1:0] cmp_raw,
   input  logic [N_CH-1:0] cmp_en,
   input  logic [N_CH-1:0] cmp_inv,
   input  logic            ph_q1,
   input  logic            ph_q3,
   input  logic            sleep_mode,
   input  logic            reg_rd,
   input  logic [N_CH-1:0] flag_clr,
   input  logic            tmr_clk,
   input  logic            sync_sel,
   output logic [N_CH-1:0] cmp_out,
   output logic [N_CH-1:0] per_out,
   output logic [N_CH-1:0] rd_data,
   output logic [N_CH-1:0] chg_flag,
   output logic [N_CH-1:0] shdn_out
);
   localparam bit HAS_SYNC = (SYNC_CH >= 0) && (SYNC_CH < N_CH);

   generate
      if (N_CH < 1) begin : g_bad_nch
         $error("cmpout_sync_unit needs at least one channel");
      end
      if (!HAS_SYNC) begin : g_bad_sync
         $error("SYNC_CH must select an existing channel");
      end
   endgenerate

   logic       follow;
   logic       rd_cap;
   logic       tmr_fall;
   sync_mode_e mode;

   assign follow = ph_q1 | sleep_mode;
   assign rd_cap = reg_rd & ph_q3;
   assign mode   = sync_mode_e'(sync_sel);

   cmpout_edge_det #(.STAGES(DET_STG)) edge_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .ext_in     (tmr_clk),
      .fall_pulse (tmr_fall)
   );

   for (genvar i = 0; i < N_CH; i++) begin : g_ch
      cmpout_chan chan_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .raw    (cmp_raw[i]),
         .en     (cmp_en[i]),
         .inv    (cmp_inv[i]),
         .follow (follow),
         .rd_cap (rd_cap),
         .clr    (flag_clr[i]),
         .out_q  (cmp_out[i]),
         .snap_q (rd_data[i]),
         .flag_q (chg_flag[i])
      );

      // Fault line comes from the live output, never from the flag.
      assign shdn_out[i] = cmp_out[i];

      if (i == SYNC_CH) begin : g_sync
         logic tsync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        tsync_q <= 1'b0;
            else if (tmr_fall) tsync_q <= cmp_out[i];
         end
         assign per_out[i] = (mode == SYNC_TIMER) ? tsync_q : cmp_out[i];
      end else begin : g_plain
         assign per_out[i] = cmp_out[i];
      end
   end
endmodule

// File: rtl/cmpout_sync_chk.sv
module cmpout_sync_chk #(
   parameter int N_CH = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic            ph_q1,
   input logic            ph_q3,
   input logic            sleep_mode,
   input logic            reg_rd,
   input logic [N_CH-1:0] flag_clr,
   input logic [N_CH-1:0] cmp_out,
   input logic [N_CH-1:0] rd_data,
   input logic [N_CH-1:0] chg_flag,
   input logic [N_CH-1:0] shdn_out
);
   // R3
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ph_q1 && !sleep_mode) |=> $stable(cmp_out));

   // R5
   snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_rd && ph_q3) |=> $stable(rd_data));

   // R6
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_out != rd_data) |=>
         ((chg_flag & $past(cmp_out ^ rd_data)) == $past(cmp_out ^ rd_data)));

   // R7
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((chg_flag & ~flag_clr) != '0) |=>
         ((chg_flag & $past(chg_flag & ~flag_clr)) == $past(chg_flag & ~flag_clr)));

   // R8
   shdn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ph_q1 && !sleep_mode) |=> $stable(shdn_out));
endmodule

bind cmpout_sync_unit cmpout_sync_chk #(.N_CH(N_CH)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .ph_q1      (ph_q1),
   .ph_q3      (ph_q3),
   .sleep_mode (sleep_mode),
   .reg_rd     (reg_rd),
   .flag_clr   (flag_clr),
   .cmp_out    (cmp_out),
   .rd_data    (rd_data),
   .chg_flag   (chg_flag),
   .shdn_out   (shdn_out)
);

// File: tb/cmpout_sync_unit_tb_top.sv
`timescale 1ns/1ps
module cmpout_sync_unit_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] cmp_raw = '0, cmp_en = '0, cmp_inv = '0, flag_clr = '0;
   logic       ph_q1 = 0, ph_q3 = 0, sleep_mode = 0, reg_rd = 0;
   logic       tmr_clk = 0, sync_sel = 0;
   logic [1:0] cmp_out, per_out, rd_data, chg_flag, shdn_out;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   cmpout_sync_unit dut_i (
      .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw), .cmp_en(cmp_en),
      .cmp_inv(cmp_inv), .ph_q1(ph_q1), .ph_q3(ph_q3), .sleep_mode(sleep_mode),
      .reg_rd(reg_rd), .flag_clr(flag_clr), .tmr_clk(tmr_clk), .sync_sel(sync_sel),
      .cmp_out(cmp_out), .per_out(per_out), .rd_data(rd_data),
      .chg_flag(chg_flag), .shdn_out(shdn_out)
   );

   // {en[1:0], inv[1:0], raw[1:0], q1, sleep, expected out[1:0]}
   localparam int NV = 9;
   localparam logic [9:0] VEC [NV] = '{
      10'b11_00_01_1_0_01,   // R3 enabled, passes raw
      10'b11_00_10_0_0_01,   // R3 no Q1: hold
      10'b11_00_10_1_0_10,   // R3
      10'b11_11_10_1_0_01,   // R3 inverted
      10'b00_10_11_1_0_10,   // R2 disabled: inv bit
      10'b01_00_11_1_0_01,   // R2 channel 1 disabled
      10'b11_00_00_0_1_00,   // R4 sleep follows
      10'b11_01_00_0_0_00,   // R3 hold
      10'b10_01_10_0_1_11    // R4 sleep follows
   };

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   initial begin
      #(20 * 5000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 cmp_out", cmp_out, 2'b00);
      check("R1 rd_data", rd_data, 2'b00);
      check("R1 chg_flag", chg_flag, 2'b00);
      check("R1 shdn_out", shdn_out, 2'b00);
      check("R1 per_out", per_out, 2'b00);
      rst_n = 1'b1;
      step();

      for (int i = 0; i < NV; i++) begin
         {cmp_en, cmp_inv, cmp_raw, ph_q1, sleep_mode} = VEC[i][9:2];
         step();
         check($sformatf("R2/R3/R4 vector %0d", i), cmp_out, VEC[i][1:0]);
         check($sformatf("R8 vector %0d", i), shdn_out, VEC[i][1:0]);
      end

      // Read and flag behaviour
      sleep_mode = 0; ph_q1 = 1; cmp_en = 2'b11; cmp_inv = 2'b00; cmp_raw = 2'b00;
      step();
      check("R3 settle", cmp_out, 2'b00);
      reg_rd = 1; ph_q3 = 1;
      step();
      reg_rd = 0; ph_q3 = 0;
      check("R5 capture", rd_data, 2'b00);
      flag_clr = 2'b11;
      step();
      flag_clr = 2'b00;
      check("R7 clear on match", chg_flag, 2'b00);
      cmp_raw = 2'b01;
      step();
      check("R3 out", cmp_out, 2'b01);
      check("R6 not yet", chg_flag, 2'b00);
      step();
      check("R6 set", chg_flag, 2'b01);
      cmp_raw = 2'b00;
      step();
      step();
      check("R6 sticky", chg_flag, 2'b01);
      flag_clr = 2'b01;
      step();
      flag_clr = 2'b00;
      check("R7 clear", chg_flag, 2'b00);
      cmp_raw = 2'b01;
      step();
      flag_clr = 2'b01;
      step();
      check("R7 set wins", chg_flag, 2'b01);
      flag_clr = 2'b00;
      reg_rd = 1; ph_q3 = 0;
      step();
      check("R5 no Q3", rd_data, 2'b00);
      ph_q3 = 1;
      step();
      reg_rd = 0; ph_q3 = 0;
      check("R5 capture 01", rd_data, 2'b01);
      check("R8 after read", shdn_out, 2'b01);
      flag_clr = 2'b01;
      step();
      flag_clr = 2'b00;
      check("R7 cleared after read", chg_flag, 2'b00);
      check("R8 after clear", shdn_out, 2'b01);

      // Timer sync option on channel 1
      sync_sel = 0;
      step();
      check("R9 bypass", per_out, cmp_out);
      tmr_clk = 1;
      step();
      step();
      sync_sel = 1; cmp_raw = 2'b11;
      step();
      check("R9 out", cmp_out, 2'b11);
      check("R9 held before fall", per_out, 2'b01);
      tmr_clk = 0;
      step();
      check("R9 one edge after fall", per_out, 2'b01);
      step();
      check("R9 two edges after fall", per_out, 2'b11);
      cmp_raw = 2'b00;
      step();
      check("R9 no new fall", per_out, 2'b10);
      sync_sel = 0;
      #1;
      check("R9 bypass again", per_out, 2'b00);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule